// File: doc/BRIEF.md
# Translation-Tagged Address Translation Cache with Invalidation

This block is a small, fully associative cache of address translations for an I/O memory management unit. Every entry records the kind of translation that produced it: bypass, first stage only, second stage only, or both stages nested. A combinational lookup port presents a page number, a guest context ID, a process context ID and the two stage mode fields. It returns hit, the physical page number and the permissions of the matching entry. A fill port writes a translation that the walker outside the block has produced.

A command port accepts two kinds of invalidation: a first-stage (virtual-memory) invalidation and a second-stage (guest-physical) invalidation. Each has three scope flags: by guest, by process and by address. An invalidation applies only to entries whose translation kind the command covers. A first-stage invalidation by process ID therefore never removes a nested translation that happens to carry the same process ID. An invalidated entry is not removed. Its permission is set to none, so later lookups miss on it, and the fill logic may reuse its slot.

Top module: `xlat_tag_tlb`

## Requirements
- R1: After a synchronous active-low reset, every entry is empty. Lookups miss with zero PPN and permission, and cmd_done and cmd_illegal are low.
- R2: A mode field equal to 0 means the stage is bare. The translation kind is derived from the two mode fields: both bare is bypass (0), first stage active only is single stage (1), second stage active only is second stage only (2), and both active is nested (3). The kind takes part in every lookup and fill match.
- R3: A lookup hits in the same cycle only when an entry's page number, guest ID, process ID and kind all equal the request and its stored permission is not none (2'b00). On a hit, lk_ppn and lk_perm carry that entry's values; on a miss both are zero.
- R4: A fill whose page, guest ID, process ID and kind equal a live entry overwrites that entry. Otherwise it takes the lowest-index free slot (never filled, or permission none). Otherwise it takes the round-robin slot, whose pointer starts at 0 and advances by one, with wraparound, only when it is used. At most one entry hits any lookup.
- R5: A legal invalidation sets the permission of each matching entry to none in the cycle it is presented, and cmd_done is high for exactly the following cycle.
- R6: A second-stage invalidation with the by-process flag set is illegal. cmd_illegal is high for the following cycle, cmd_done stays low, and no entry changes.
- R7: A second-stage invalidation covers second-stage-only and nested entries. Without by-guest it clears all of them. With by-guest it clears those whose guest ID matches, and with by-guest and by-address it clears those whose guest ID and page both match.
- R8: A first-stage invalidation with by-guest covers only nested entries. It always matches the guest ID, and it also matches the process ID when by-process is set and the page when by-address is set.
- R9: A first-stage invalidation without by-guest covers only single-stage entries. It matches the process ID when by-process is set and the page when by-address is set; with neither flag set it clears every single-stage entry.
- R10: Bypass entries are never affected by any invalidation.
- R11: The invalidation page number is taken from cmd_addr_word shifted left by two and masked to a 4 KiB boundary: it equals cmd_addr_word[VPN_W+9:10], and bits 9:0 are ignored.
- R12: A lookup in the same cycle as an invalidation sees the entries as they were before the invalidation. A fill in that same cycle is written and is not cleared by that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_gid | input | GID_W | Lookup guest context ID |
| lk_pid | input | PID_W | Lookup process context ID |
| lk_s1_mode | input | MODE_W | First-stage mode field of the requester (0 = bare) |
| lk_s2_mode | input | MODE_W | Second-stage mode field of the requester (0 = bare) |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page number on a hit, else 0 |
| lk_perm | output | PERM_W | Permissions on a hit, else 0 |
| fl_valid | input | 1 | Fill strobe |
| fl_vpn | input | VPN_W | Fill page number |
| fl_gid | input | GID_W | Fill guest context ID |
| fl_pid | input | PID_W | Fill process context ID |
| fl_s1_mode | input | MODE_W | First-stage mode field of the filling context |
| fl_s2_mode | input | MODE_W | Second-stage mode field of the filling context |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_perm | input | PERM_W | Fill permissions (0 = none) |
| cmd_valid | input | 1 | Invalidation command strobe |
| cmd_stage2 | input | 1 | 1 = second-stage invalidation, 0 = first-stage |
| cmd_by_guest | input | 1 | Scope flag: match guest ID |
| cmd_by_addr | input | 1 | Scope flag: match page |
| cmd_by_proc | input | 1 | Scope flag: match process ID |
| cmd_gid | input | GID_W | Command guest context ID |
| cmd_pid | input | PID_W | Command process context ID |
| cmd_addr_word | input | 64 | Raw address word of the command |
| cmd_done | output | 1 | Legal command completed (one cycle after it) |
| cmd_illegal | output | 1 | Illegal command flagged (one cycle after it) |

## Verification
The bench builds the block with ENTRIES set to 4 and the default field widths. With only four slots, the round-robin pointer, its wraparound, and the choice between overwriting a duplicate, reusing a freed slot and evicting take only a few fills. The full 44-bit page width keeps the address extraction from the shifted command word at its real bit positions, so the bench can fill the ignored low bits with ones and see them dropped. Stimulus places entries of all four kinds with shared guest and process IDs side by side, so that each command's kind filter is seen separately from its ID and address filters.

// File: rtl/xlat_pkg.sv
// Package: shared translation-kind type and its derivation from the two
// stage mode fields. Assumes a mode field value of zero means "bare".
package xlat_pkg;

    typedef enum logic [1:0] {
        KIND_BYPASS = 2'd0,
        KIND_STAGE1 = 2'd1,
        KIND_STAGE2 = 2'd2,
        KIND_NESTED = 2'd3
    } kind_e;

    // Map the two "stage active" indications onto a translation kind.
    function automatic kind_e kind_of(input logic s1_active, input logic s2_active);
        kind_e k;
        case ({s1_active, s2_active})
            2'b00:   k = KIND_BYPASS;
            2'b01:   k = KIND_STAGE2;
            2'b10:   k = KIND_STAGE1;
            default: k = KIND_NESTED;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/xlat_key_match.sv
// Module: full-key comparator for one entry. Reports equality of page,
// guest ID, process ID and translation kind. Validity and permission
// gating are left to the caller.
module xlat_key_match #(
    parameter int VPN_W = 44,
    parameter int GID_W = 16,
    parameter int PID_W = 20
) (
    input  logic [VPN_W-1:0]    e_vpn,
    input  logic [GID_W-1:0]    e_gid,
    input  logic [PID_W-1:0]    e_pid,
    input  xlat_pkg::kind_e     e_kind,
    input  logic [VPN_W-1:0]    k_vpn,
    input  logic [GID_W-1:0]    k_gid,
    input  logic [PID_W-1:0]    k_pid,
    input  xlat_pkg::kind_e     k_kind,
    output logic                eq
);
    // Compare all four key fields at once.
    always_comb begin
        eq = (e_vpn == k_vpn) && (e_gid == k_gid) &&
             (e_pid == k_pid) && (e_kind == k_kind);
    end
endmodule

// File: rtl/xlat_inval_match.sv
// Module: per-entry invalidation filter. A decoded command gives the set
// of kinds it covers and which of guest ID, process ID and page must
// match. Assumes the caller gates the result with the entry's validity.
module xlat_inval_match #(
    parameter int VPN_W = 44,
    parameter int GID_W = 16,
    parameter int PID_W = 20
) (
    input  logic [VPN_W-1:0]    e_vpn,
    input  logic [GID_W-1:0]    e_gid,
    input  logic [PID_W-1:0]    e_pid,
    input  xlat_pkg::kind_e     e_kind,
    input  logic [3:0]          kind_mask,
    input  logic                chk_gid,
    input  logic                chk_pid,
    input  logic                chk_vpn,
    input  logic [VPN_W-1:0]    c_vpn,
    input  logic [GID_W-1:0]    c_gid,
    input  logic [PID_W-1:0]    c_pid,
    output logic                clr
);
    // Kind must be covered; each enabled field must also match.
    always_comb begin
        clr = kind_mask[e_kind] &&
              (!chk_gid || (e_gid == c_gid)) &&
              (!chk_pid || (e_pid == c_pid)) &&
              (!chk_vpn || (e_vpn == c_vpn));
    end
endmodule

// File: rtl/xlat_victim_sel.sv
// Module: fill slot chooser. Priority: an existing live entry with the
// same key, then the lowest-index free slot, then the round-robin slot.
// Assumes dup_vec has at most one bit set.
module xlat_victim_sel #(
    parameter int ENTRIES = 8,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                en,
    input  logic [ENTRIES-1:0]  dup_vec,
    input  logic [ENTRIES-1:0]  free_vec,
    input  logic [PTR_W-1:0]    rr_ptr,
    output logic [ENTRIES-1:0]  sel,
    output logic                rr_used
);
    logic [ENTRIES-1:0] low_free;

    // Isolate the lowest set bit of the free vector.
    always_comb begin
        low_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                low_free    = '0;
                low_free[i] = 1'b1;
            end
        end
    end

    // Apply the priority order and report round-robin use.
    always_comb begin
        sel     = '0;
        rr_used = 1'b0;
        if (en) begin
            if (|dup_vec) begin
                sel = dup_vec;
            end else if (|free_vec) begin
                sel = low_free;
            end else begin
                sel[rr_ptr] = 1'b1;
                rr_used     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_tag_tlb.sv
// Module: fully associative translation cache whose entries carry a
// translation-kind tag. Lookup is combinational on the current state.
// Fill and invalidation take effect at the clock edge; a fill wins over
// an invalidation on the same slot. Assumes VPN_W + 10 <= 64.
module xlat_tag_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 44,
    parameter int PPN_W   = 44,
    parameter int GID_W   = 16,
    parameter int PID_W   = 20,
    parameter int MODE_W  = 4,
    parameter int PERM_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [GID_W-1:0]    lk_gid,
    input  logic [PID_W-1:0]    lk_pid,
    input  logic [MODE_W-1:0]   lk_s1_mode,
    input  logic [MODE_W-1:0]   lk_s2_mode,
    output logic                lk_hit,
    output logic [PPN_W-1:0]    lk_ppn,
    output logic [PERM_W-1:0]   lk_perm,
    input  logic                fl_valid,
    input  logic [VPN_W-1:0]    fl_vpn,
    input  logic [GID_W-1:0]    fl_gid,
    input  logic [PID_W-1:0]    fl_pid,
    input  logic [MODE_W-1:0]   fl_s1_mode,
    input  logic [MODE_W-1:0]   fl_s2_mode,
    input  logic [PPN_W-1:0]    fl_ppn,
    input  logic [PERM_W-1:0]   fl_perm,
    input  logic                cmd_valid,
    input  logic                cmd_stage2,
    input  logic                cmd_by_guest,
    input  logic                cmd_by_addr,
    input  logic                cmd_by_proc,
    input  logic [GID_W-1:0]    cmd_gid,
    input  logic [PID_W-1:0]    cmd_pid,
    input  logic [63:0]         cmd_addr_word,
    output logic                cmd_done,
    output logic                cmd_illegal
);
    import xlat_pkg::*;

    localparam int PTR_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int ADDR_LSB = 10;  // word << 2, then drop 12 page-offset bits

    // Entry storage
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
    logic [ENTRIES-1:0][1:0]        kind_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][GID_W-1:0]  gid_q;
    logic [ENTRIES-1:0][PID_W-1:0]  pid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [PTR_W-1:0]               rr_ptr_q;
    logic                           done_q;
    logic                           illegal_q;

    // Per-entry match results
    logic [ENTRIES-1:0] lk_eq, fl_eq, inv_eq;
    logic [ENTRIES-1:0] live, lk_hit_vec, dup_vec, free_vec, inval_vec;
    logic [ENTRIES-1:0] fill_sel;
    logic               rr_used;

    kind_e lk_kind, fl_kind;

    // Decoded command
    logic             cmd_legal, inval_en;
    logic [3:0]       kind_mask;
    logic             chk_gid, chk_pid, chk_vpn;
    logic [VPN_W-1:0] cmd_vpn;

    // Kinds of the lookup and fill requests from their mode fields.
    always_comb begin
        lk_kind = kind_of(|lk_s1_mode, |lk_s2_mode);
        fl_kind = kind_of(|fl_s1_mode, |fl_s2_mode);
    end

    // Decode the command into covered kinds and field checks.
    always_comb begin
        cmd_legal = !(cmd_stage2 && cmd_by_proc);
        inval_en  = cmd_valid && cmd_legal;
        cmd_vpn   = cmd_addr_word[VPN_W+ADDR_LSB-1:ADDR_LSB];
        kind_mask = '0;
        if (cmd_stage2) begin
            kind_mask[KIND_STAGE2] = 1'b1;
            kind_mask[KIND_NESTED] = 1'b1;
        end else if (cmd_by_guest) begin
            kind_mask[KIND_NESTED] = 1'b1;
        end else begin
            kind_mask[KIND_STAGE1] = 1'b1;
        end
        chk_gid = cmd_by_guest;
        chk_pid = !cmd_stage2 && cmd_by_proc;
        chk_vpn = cmd_by_addr && (!cmd_stage2 || cmd_by_guest);
    end

    // Per-entry comparators and storage.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        xlat_key_match #(.VPN_W(VPN_W), .GID_W(GID_W), .PID_W(PID_W)) u_lk (
            .e_vpn(vpn_q[i]), .e_gid(gid_q[i]), .e_pid(pid_q[i]),
            .e_kind(kind_e'(kind_q[i])),
            .k_vpn(lk_vpn), .k_gid(lk_gid), .k_pid(lk_pid), .k_kind(lk_kind),
            .eq(lk_eq[i])
        );

        xlat_key_match #(.VPN_W(VPN_W), .GID_W(GID_W), .PID_W(PID_W)) u_fl (
            .e_vpn(vpn_q[i]), .e_gid(gid_q[i]), .e_pid(pid_q[i]),
            .e_kind(kind_e'(kind_q[i])),
            .k_vpn(fl_vpn), .k_gid(fl_gid), .k_pid(fl_pid), .k_kind(fl_kind),
            .eq(fl_eq[i])
        );

        xlat_inval_match #(.VPN_W(VPN_W), .GID_W(GID_W), .PID_W(PID_W)) u_inv (
            .e_vpn(vpn_q[i]), .e_gid(gid_q[i]), .e_pid(pid_q[i]),
            .e_kind(kind_e'(kind_q[i])),
            .kind_mask(kind_mask), .chk_gid(chk_gid), .chk_pid(chk_pid),
            .chk_vpn(chk_vpn), .c_vpn(cmd_vpn), .c_gid(cmd_gid), .c_pid(cmd_pid),
            .clr(inv_eq[i])
        );

        // Classify the entry for lookup, fill and invalidation.
        always_comb begin
            live[i]       = valid_q[i] && (perm_q[i] != '0);
            lk_hit_vec[i] = live[i] && lk_eq[i];
            dup_vec[i]    = live[i] && fl_eq[i];
            free_vec[i]   = !live[i];
            inval_vec[i]  = inval_en && valid_q[i] && inv_eq[i];
        end

        // Control state: fill writes, else invalidation clears permission.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                perm_q[i]  <= '0;
                kind_q[i]  <= KIND_BYPASS;
            end else if (fill_sel[i]) begin
                valid_q[i] <= 1'b1;
                perm_q[i]  <= fl_perm;
                kind_q[i]  <= fl_kind;
            end else if (inval_vec[i]) begin
                perm_q[i]  <= '0;
            end
        end

        // Payload state: written only by a fill into this slot.
        always_ff @(posedge clk) begin
            if (fill_sel[i]) begin
                vpn_q[i] <= fl_vpn;
                gid_q[i] <= fl_gid;
                pid_q[i] <= fl_pid;
                ppn_q[i] <= fl_ppn;
            end
        end
    end

    xlat_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .en(fl_valid), .dup_vec(dup_vec), .free_vec(free_vec),
        .rr_ptr(rr_ptr_q), .sel(fill_sel), .rr_used(rr_used)
    );

    // Merge the hit entry's payload onto the lookup outputs.
    always_comb begin
        lk_hit  = |lk_hit_vec;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) begin
                lk_ppn  = lk_ppn | ppn_q[i];
                lk_perm = lk_perm | perm_q[i];
            end
        end
    end

    // Round-robin pointer: advances only when it supplied the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (rr_used) begin
            rr_ptr_q <= (rr_ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr_q + 1'b1;
        end
    end

    // Completion and illegal-command pulses, one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= inval_en;
            illegal_q <= cmd_valid && !cmd_legal;
        end
    end

    assign cmd_done    = done_q;
    assign cmd_illegal = illegal_q;

endmodule

// File: rtl/xlat_tag_tlb_chk.sv
// Module: assertion checker for xlat_tag_tlb, attached by bind below.
// Observes ports plus the entry control state and the lookup hit vector.
module xlat_tag_tlb_chk #(
    parameter int ENTRIES = 8,
    parameter int PERM_W  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cmd_valid,
    input  logic                            cmd_stage2,
    input  logic                            cmd_by_proc,
    input  logic                            fl_valid,
    input  logic                            lk_hit,
    input  logic [PERM_W-1:0]               lk_perm,
    input  logic                            cmd_done,
    input  logic                            cmd_illegal,
    input  logic [ENTRIES-1:0]              valid_q,
    input  logic [ENTRIES-1:0][PERM_W-1:0]  perm_q,
    input  logic [ENTRIES-1:0][1:0]         kind_q,
    input  logic [ENTRIES-1:0]              lk_hit_vec
);
    logic [ENTRIES-1:0] byp_live;

    // Live bypass entries, recomputed here from stored state.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            byp_live[i] = valid_q[i] && (kind_q[i] == 2'd0) && (perm_q[i] != '0);
        end
    end

    // R1: leaving reset, no entry is valid and no pulse is pending.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0) && !cmd_done && !cmd_illegal);

    // R3: a hit always reports a permission other than none.
    p_hit_has_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_perm != '0));

    // R4: at most one entry matches any lookup.
    p_single_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

    // R5: a legal command yields a done pulse on the next cycle.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !(cmd_stage2 && cmd_by_proc)) |=> cmd_done && !cmd_illegal);

    // R5: no done pulse without a command in the previous cycle.
    p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_done && !cmd_illegal);

    // R6: an illegal command is flagged and not reported as done.
    p_illegal_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stage2 && cmd_by_proc) |=> cmd_illegal && !cmd_done);

    // R6: an illegal command leaves every permission untouched.
    p_illegal_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stage2 && cmd_by_proc && !fl_valid) |=> $stable(perm_q));

    // R10: without a fill, a live bypass entry stays live.
    p_bypass_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_valid |=> ((byp_live & $past(byp_live)) == $past(byp_live)));

endmodule

bind xlat_tag_tlb xlat_tag_tlb_chk #(.ENTRIES(ENTRIES), .PERM_W(PERM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_stage2(cmd_stage2),
    .cmd_by_proc(cmd_by_proc), .fl_valid(fl_valid), .lk_hit(lk_hit),
    .lk_perm(lk_perm), .cmd_done(cmd_done), .cmd_illegal(cmd_illegal),
    .valid_q(valid_q), .perm_q(perm_q), .kind_q(kind_q), .lk_hit_vec(lk_hit_vec)
);

// File: tb/xlat_tag_tlb_tb_top.sv
// Bench: directed scenarios, one task each, checking their own results.
module xlat_tag_tlb_tb_top;
    localparam int ENTRIES = 4;
    localparam int VPN_W = 44, PPN_W = 44, GID_W = 16, PID_W = 20;
    localparam int MODE_W = 4, PERM_W = 2;
    localparam logic [MODE_W-1:0] BARE = 4'd0, ACT = 4'd8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0, fl_vpn = '0;
    logic [GID_W-1:0] lk_gid = '0, fl_gid = '0, cmd_gid = '0;
    logic [PID_W-1:0] lk_pid = '0, fl_pid = '0, cmd_pid = '0;
    logic [MODE_W-1:0] lk_s1_mode = '0, lk_s2_mode = '0, fl_s1_mode = '0, fl_s2_mode = '0;
    logic lk_hit;
    logic [PPN_W-1:0] lk_ppn, fl_ppn = '0;
    logic [PERM_W-1:0] lk_perm, fl_perm = '0;
    logic fl_valid = 1'b0, cmd_valid = 1'b0, cmd_stage2 = 1'b0;
    logic cmd_by_guest = 1'b0, cmd_by_addr = 1'b0, cmd_by_proc = 1'b0;
    logic [63:0] cmd_addr_word = '0;
    logic cmd_done, cmd_illegal;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    xlat_tag_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .GID_W(GID_W),
                   .PID_W(PID_W), .MODE_W(MODE_W), .PERM_W(PERM_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_gid(lk_gid), .lk_pid(lk_pid),
        .lk_s1_mode(lk_s1_mode), .lk_s2_mode(lk_s2_mode),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_gid(fl_gid), .fl_pid(fl_pid),
        .fl_s1_mode(fl_s1_mode), .fl_s2_mode(fl_s2_mode), .fl_ppn(fl_ppn), .fl_perm(fl_perm),
        .cmd_valid(cmd_valid), .cmd_stage2(cmd_stage2), .cmd_by_guest(cmd_by_guest),
        .cmd_by_addr(cmd_by_addr), .cmd_by_proc(cmd_by_proc), .cmd_gid(cmd_gid),
        .cmd_pid(cmd_pid), .cmd_addr_word(cmd_addr_word),
        .cmd_done(cmd_done), .cmd_illegal(cmd_illegal)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive fill fields (no strobe change).
    task automatic set_fill(input logic [VPN_W-1:0] v, input logic [GID_W-1:0] g,
                            input logic [PID_W-1:0] p, input logic [MODE_W-1:0] m1,
                            input logic [MODE_W-1:0] m2, input logic [PPN_W-1:0] ppn);
        fl_vpn = v; fl_gid = g; fl_pid = p; fl_s1_mode = m1; fl_s2_mode = m2;
        fl_ppn = ppn; fl_perm = 2'b11;
    endtask

    task automatic do_fill(input logic [VPN_W-1:0] v, input logic [GID_W-1:0] g,
                           input logic [PID_W-1:0] p, input logic [MODE_W-1:0] m1,
                           input logic [MODE_W-1:0] m2, input logic [PPN_W-1:0] ppn);
        @(negedge clk);
        set_fill(v, g, p, m1, m2, ppn);
        fl_valid = 1'b1;
        @(negedge clk);
        fl_valid = 1'b0;
    endtask

    // Drive command fields (no strobe change). Address word = vpn << 10 | ignored low bits.
    task automatic set_cmd(input logic s2, input logic bg, input logic ba, input logic bp,
                           input logic [GID_W-1:0] g, input logic [PID_W-1:0] p,
                           input logic [VPN_W-1:0] v);
        cmd_stage2 = s2; cmd_by_guest = bg; cmd_by_addr = ba; cmd_by_proc = bp;
        cmd_gid = g; cmd_pid = p;
        cmd_addr_word = (64'(v) << 10) | 64'h3FF;
    endtask

    // Issue a command; on the next cycle check the done/illegal pulses.
    task automatic do_cmd(input logic s2, input logic bg, input logic ba, input logic bp,
                          input logic [GID_W-1:0] g, input logic [PID_W-1:0] p,
                          input logic [VPN_W-1:0] v, input logic exp_ill);
        @(negedge clk);
        set_cmd(s2, bg, ba, bp, g, p, v);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(64'(cmd_done), 64'(!exp_ill), "R5 done pulse");
        check(64'(cmd_illegal), 64'(exp_ill), "R6 illegal pulse");
        @(negedge clk);
        check(64'(cmd_done | cmd_illegal), 64'd0, "R5 pulse lasts one cycle");
    endtask

    task automatic probe(input logic [VPN_W-1:0] v, input logic [GID_W-1:0] g,
                         input logic [PID_W-1:0] p, input logic [MODE_W-1:0] m1,
                         input logic [MODE_W-1:0] m2, input logic exp_hit,
                         input logic [PPN_W-1:0] exp_ppn, input string req);
        @(negedge clk);
        lk_vpn = v; lk_gid = g; lk_pid = p; lk_s1_mode = m1; lk_s2_mode = m2;
        #1;
        check(64'(lk_hit), 64'(exp_hit), {req, " hit"});
        check(64'(lk_ppn), exp_hit ? 64'(exp_ppn) : 64'd0, {req, " ppn"});
        check(64'(lk_perm), exp_hit ? 64'd3 : 64'd0, {req, " perm"});
    endtask

    task automatic t_reset();
        do_reset();
        probe(0, 0, 0, BARE, BARE, 1'b0, 0, "R1 empty after reset");
        check(64'(cmd_done | cmd_illegal), 64'd0, "R1 pulses low after reset");
    endtask

    // One entry of each kind with equal IDs and page; then a first-stage
    // invalidation by process must spare the nested entry.
    task automatic t_kinds_and_vma_proc();
        do_reset();
        do_fill(44'h100, 16'd1, 20'd5, ACT,  BARE, 44'hA1);
        do_fill(44'h100, 16'd1, 20'd5, ACT,  ACT,  44'hA2);
        do_fill(44'h100, 16'd1, 20'd5, BARE, ACT,  44'hA3);
        do_fill(44'h100, 16'd1, 20'd5, BARE, BARE, 44'hA4);
        probe(44'h100, 16'd1, 20'd5, ACT,  BARE, 1'b1, 44'hA1, "R2 single stage kind");
        probe(44'h100, 16'd1, 20'd5, ACT,  ACT,  1'b1, 44'hA2, "R2 nested kind");
        probe(44'h100, 16'd1, 20'd5, BARE, ACT,  1'b1, 44'hA3, "R2 stage2-only kind");
        probe(44'h100, 16'd1, 20'd5, BARE, BARE, 1'b1, 44'hA4, "R2 bypass kind");
        probe(44'h100, 16'd1, 20'd6, ACT,  BARE, 1'b0, 0, "R3 process ID mismatch");
        probe(44'h101, 16'd1, 20'd5, ACT,  BARE, 1'b0, 0, "R3 page mismatch");
        probe(44'h100, 16'd2, 20'd5, ACT,  ACT,  1'b0, 0, "R3 guest ID mismatch");
        do_cmd(1'b0, 1'b0, 1'b0, 1'b1, 16'd0, 20'd5, 44'h0, 1'b0);
        probe(44'h100, 16'd1, 20'd5, ACT,  BARE, 1'b0, 0, "R9 single stage cleared by process");
        probe(44'h100, 16'd1, 20'd5, ACT,  ACT,  1'b1, 44'hA2, "R9 nested spared");
        probe(44'h100, 16'd1, 20'd5, BARE, ACT,  1'b1, 44'hA3, "R9 stage2-only spared");
        probe(44'h100, 16'd1, 20'd5, BARE, BARE, 1'b1, 44'hA4, "R10 bypass spared");
        // Illegal second-stage command with by-process changes nothing.
        do_cmd(1'b1, 1'b0, 1'b0, 1'b1, 16'd1, 20'd5, 44'h0, 1'b1);
        probe(44'h100, 16'd1, 20'd5, ACT,  ACT,  1'b1, 44'hA2, "R6 nested kept");
        probe(44'h100, 16'd1, 20'd5, BARE, ACT,  1'b1, 44'hA3, "R6 stage2-only kept");
    endtask

    // Second-stage invalidations by guest, then global; bypass survives.
    task automatic t_gvma();
        do_reset();
        do_fill(44'h10, 16'd1, 20'd0, ACT,  ACT,  44'hB1);
        do_fill(44'h10, 16'd2, 20'd0, BARE, ACT,  44'hB2);
        do_fill(44'h10, 16'd1, 20'd0, BARE, BARE, 44'hB3);
        do_fill(44'h10, 16'd1, 20'd0, ACT,  BARE, 44'hB4);
        do_cmd(1'b1, 1'b1, 1'b1, 1'b0, 16'd2, 20'd0, 44'h11, 1'b0);
        probe(44'h10, 16'd2, 20'd0, BARE, ACT, 1'b1, 44'hB2, "R7 guest+addr other page kept");
        do_cmd(1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 20'd0, 44'h0, 1'b0);
        probe(44'h10, 16'd1, 20'd0, ACT,  ACT,  1'b0, 0, "R7 nested guest 1 cleared");
        probe(44'h10, 16'd2, 20'd0, BARE, ACT,  1'b1, 44'hB2, "R7 other guest kept");
        probe(44'h10, 16'd1, 20'd0, ACT,  BARE, 1'b1, 44'hB4, "R7 single stage untouched");
        do_cmd(1'b1, 1'b0, 1'b1, 1'b0, 16'd0, 20'd0, 44'h77, 1'b0);
        probe(44'h10, 16'd2, 20'd0, BARE, ACT,  1'b0, 0, "R7 global clears stage2-only");
        probe(44'h10, 16'd1, 20'd0, BARE, BARE, 1'b1, 44'hB3, "R10 bypass after global");
        probe(44'h10, 16'd1, 20'd0, ACT,  BARE, 1'b1, 44'hB4, "R7 single stage after global");
    endtask

    // First-stage invalidations with by-guest (nested) and by-address.
    task automatic t_vma_nested_addr();
        do_reset();
        do_fill(44'h100, 16'd3, 20'd7, ACT, ACT,  44'hC1);
        do_fill(44'h200, 16'd3, 20'd7, ACT, ACT,  44'hC2);
        do_fill(44'h100, 16'd4, 20'd7, ACT, ACT,  44'hC3);
        do_fill(44'h100, 16'd3, 20'd7, ACT, BARE, 44'hC4);
        do_cmd(1'b0, 1'b1, 1'b1, 1'b1, 16'd3, 20'd7, 44'h100, 1'b0);
        probe(44'h100, 16'd3, 20'd7, ACT, ACT,  1'b0, 0, "R8 nested guest+proc+addr cleared");
        probe(44'h200, 16'd3, 20'd7, ACT, ACT,  1'b1, 44'hC2, "R11 other page kept");
        probe(44'h100, 16'd4, 20'd7, ACT, ACT,  1'b1, 44'hC3, "R8 other guest kept");
        probe(44'h100, 16'd3, 20'd7, ACT, BARE, 1'b1, 44'hC4, "R8 single stage spared");
        do_cmd(1'b0, 1'b1, 1'b0, 1'b1, 16'd3, 20'd8, 44'h0, 1'b0);
        probe(44'h200, 16'd3, 20'd7, ACT, ACT,  1'b1, 44'hC2, "R8 other process kept");
        do_cmd(1'b0, 1'b0, 1'b1, 1'b0, 16'd0, 20'd0, 44'h100, 1'b0);
        probe(44'h100, 16'd3, 20'd7, ACT, BARE, 1'b0, 0, "R9 single stage by addr cleared");
        probe(44'h100, 16'd4, 20'd7, ACT, ACT,  1'b1, 44'hC3, "R9 nested spared by addr");
    endtask

    // Victim order: free slots, round robin, overwrite, reuse of freed slot.
    task automatic t_replace();
        do_reset();
        for (int i = 1; i <= 4; i++) do_fill(44'(i), 16'd0, 20'd0, ACT, BARE, 44'(16 + i));
        for (int i = 1; i <= 4; i++) probe(44'(i), 16'd0, 20'd0, ACT, BARE, 1'b1, 44'(16 + i), "R4 all slots filled");
        do_fill(44'd5, 16'd0, 20'd0, ACT, BARE, 44'h15);
        probe(44'd1, 16'd0, 20'd0, ACT, BARE, 1'b0, 0, "R4 slot 0 evicted first");
        probe(44'd5, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h15, "R4 new entry present");
        do_fill(44'd6, 16'd0, 20'd0, ACT, BARE, 44'h16);
        probe(44'd2, 16'd0, 20'd0, ACT, BARE, 1'b0, 0, "R4 slot 1 evicted second");
        do_fill(44'd3, 16'd0, 20'd0, ACT, BARE, 44'h33);
        probe(44'd3, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h33, "R4 same key overwritten");
        probe(44'd4, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h14, "R4 overwrite evicts nothing");
        do_cmd(1'b0, 1'b0, 1'b1, 1'b0, 16'd0, 20'd0, 44'd4, 1'b0);
        do_fill(44'd7, 16'd0, 20'd0, ACT, BARE, 44'h17);
        probe(44'd3, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h33, "R4 freed slot reused, not rr");
        probe(44'd5, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h15, "R4 slot 0 kept");
        probe(44'd6, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h16, "R4 slot 1 kept");
        probe(44'd7, 16'd0, 20'd0, ACT, BARE, 1'b1, 44'h17, "R4 new entry in freed slot");
    endtask

    // Lookup and fill in the same cycle as an invalidation.
    task automatic t_same_cycle();
        do_reset();
        do_fill(44'h40, 16'd0, 20'd9, ACT, BARE, 44'h400);
        @(negedge clk);
        set_cmd(1'b0, 1'b0, 1'b0, 1'b1, 16'd0, 20'd9, 44'h0);
        cmd_valid = 1'b1;
        set_fill(44'h41, 16'd0, 20'd9, ACT, BARE, 44'h410);
        fl_valid = 1'b1;
        lk_vpn = 44'h40; lk_gid = 16'd0; lk_pid = 20'd9; lk_s1_mode = ACT; lk_s2_mode = BARE;
        #1;
        check(64'(lk_hit), 64'd1, "R12 lookup sees pre-invalidation state");
        check(64'(lk_ppn), 64'h400, "R12 lookup ppn before invalidation");
        @(negedge clk);
        cmd_valid = 1'b0;
        fl_valid = 1'b0;
        check(64'(cmd_done), 64'd1, "R5 done after same-cycle command");
        probe(44'h40, 16'd0, 20'd9, ACT, BARE, 1'b0, 0, "R12 old entry cleared");
        probe(44'h41, 16'd0, 20'd9, ACT, BARE, 1'b1, 44'h410, "R12 same-cycle fill survives");
    endtask

    initial begin
        t_reset();
        t_kinds_and_vma_proc();
        t_gvma();
        t_vma_nested_addr();
        t_replace();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule